// File: doc/BRIEF.md
# Multiplexed Address/Data Peripheral Bus Master

This block runs a narrow external parallel bus that reaches one boot EPROM and two PHY devices. All three share an 8-bit bidirectional data lane. The address is not given pins of its own: it is sent over the data lane one byte at a time. Each byte has its own active-high latch strobe, so that external octal latches or a PHY that demultiplexes the lane can capture it. Address bit 17 always leaves on a dedicated pin. Address bit 16 has a dedicated pin as well, and a strap sampled during reset decides its role. When the pin is pulled low, it becomes a third latch strobe, and the EPROM then gets a full 24-bit address through three byte phases.

The host side offers one request at a time. The request carries a target code, a read/write flag, a 24-bit address, up to 16 bits of write data and a wait count. The request is taken only while the block is idle. The block returns read data and a parity-error flag together with a one-cycle done pulse. Two options are picked per request. The first makes the 8-bit lane carry an odd parity bit on a side pin. The second runs PHY accesses 16 bits wide on an upper lane, and in that case only the low address byte is sent. The data lane obeys a sustained tri-state rule: the block parks a line high before it lets go of it, and it leaves one idle clock after a read target lets go.

Top module: `pbm_bus_master`

## Requirements
- R1: In the cycle after any clock edge with `rst` high, all three selects are high, `ale1`, `ale2`, `a16_o`, `a17_o`, `bus_d_oe`, `bus_hi_oe`, `par_oe`, `busy` and `rsp_done` are low.
- R2: During the data phase only the requested target's select is low. Target code 0 is the EPROM, 1 is PHY1 and 2 is PHY2. No select is ever low at the same time as a latch strobe.
- R3: Each address byte takes two clocks, with the byte held on `bus_d_o` for both. The strobe for that byte is high only in the first clock. Bytes go out highest first. The address[7:0] byte, strobed by `ale1`, is always sent.
- R4: The address[15:8] byte, strobed by `ale2`, is sent for every access except a PHY access in wide mode.
- R5: If `a16_strap_i` is low in a reset cycle, `a16_o` serves as the strobe for an address[23:16] byte, and that byte is sent for EPROM accesses only. With the strap high, no third byte is ever sent.
- R6: During an EPROM access, `a17_o` carries address[17], and with the strap high `a16_o` carries address[16]. During PHY accesses both pins stay low, apart from the R5 strobe.
- R7: The data phase lasts `cfg_wait`+1 clocks with the select low. A write keeps `req_wdata`[7:0] on `bus_d_o` for the whole phase. A read captures `bus_d_i` on the last clock of the phase. `rsp_rdata` shows the captured value, or zero after a write.
- R8: In wide mode a PHY write drives `req_wdata`[15:8] on `bus_hi_o`, and a PHY read returns `bus_hi_i` in `rsp_rdata`[15:8]. Otherwise `rsp_rdata`[15:8] is zero and `bus_hi_oe` stays low.
- R9: With parity on, `par_oe` is high whenever `bus_d_oe` is high, and `par_o` makes the count of ones in {`bus_d_o`,`par_o`} odd. A read whose `par_i` breaks that rule for the captured byte raises `rsp_perr` together with `rsp_done`. With parity off, `par_oe` and `rsp_perr` stay low.
- R10: `bus_d_o` is 8'hFF in the clock before `bus_d_oe` falls. After a read's select rises, `bus_d_oe` stays low for at least one clock.
- R11: `rsp_done` is a one-clock pulse with P address bytes and N data clocks. It comes 2P+N+2 clocks after the accepting edge for a write and 2P+N+3 clocks after it for a read. `busy` is high from that edge until done. A request made while busy, or one with target code 3, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap sampled while high |
| req_valid | input | 1 | Request offered (taken only when idle) |
| req_target | input | 2 | 0 EPROM, 1 PHY1, 2 PHY2, 3 invalid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (upper byte used in wide PHY mode) |
| cfg_wait | input | 4 | Data phase length minus one |
| cfg_wide | input | 1 | 16-bit PHY data mode |
| cfg_parity | input | 1 | Odd parity on the low data lane |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| rsp_perr | output | 1 | Read parity mismatch, valid with done |
| sel_eprom_n | output | 1 | EPROM select, active low |
| sel_phy1_n | output | 1 | PHY1 select, active low |
| sel_phy2_n | output | 1 | PHY2 select, active low |
| ale1 | output | 1 | Strobe for address[7:0] |
| ale2 | output | 1 | Strobe for address[15:8] |
| a16_strap_i | input | 1 | Reset-time strap read from the address-16 pin |
| a16_o | output | 1 | Address[16] or third strobe |
| a17_o | output | 1 | Address[17] |
| bus_d_o | output | 8 | Low data lane out |
| bus_d_i | input | 8 | Low data lane in |
| bus_d_oe | output | 1 | Low data lane drive enable |
| bus_hi_o | output | 8 | Upper data lane out |
| bus_hi_i | input | 8 | Upper data lane in |
| bus_hi_oe | output | 1 | Upper data lane drive enable |
| par_o | output | 1 | Parity out |
| par_i | input | 1 | Parity in |
| par_oe | output | 1 | Parity drive enable |

## Verification
The bench plays the part of the targets. Its read model puts the correct byte on the lane only in the last select clock and the inverted byte before that, so a design that captures early or late returns the wrong data. Strap-low and strap-high resets are both run. A design that sends the third byte to a PHY, or sends it without the strap, shows up as a wrong strobe count and a wrong done latency. Wide PHY accesses check that the middle byte is dropped and that the upper lane carries data. A deliberately bad parity bit must raise the error flag. Requests made while busy, and requests with the invalid target code, must produce no extra done pulse. Every release of the low lane is checked for a preceding all-ones park byte.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  typedef enum logic [1:0] {
    TGT_EPROM = 2'd0,
    TGT_PHY1  = 2'd1,
    TGT_PHY2  = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_PARK_R = 3'd2,
    ST_GAP    = 3'd3,
    ST_DATA   = 3'd4,
    ST_PARK_W = 3'd5,
    ST_TURN   = 3'd6
  } st_e;

  // byte phases: 0 = low byte, 1 = middle byte, 2 = high byte
  localparam int NUM_PH = 3;
  localparam int IDX_W  = 2;

endpackage

// File: rtl/pbm_phase_plan.sv
module pbm_phase_plan
  import pbm_pkg::*;
(
  input  tgt_e             tgt,
  input  logic             ale3_mode,
  input  logic             wide,
  input  logic [IDX_W-1:0] cur,
  output logic [NUM_PH-1:0] need,
  output logic [IDX_W-1:0] first,
  output logic [IDX_W-1:0] nxt,
  output logic             nxt_ok
);

  always_comb begin
    need    = '0;
    need[0] = 1'b1;
    need[1] = !(wide && (tgt != TGT_EPROM));
    need[2] = ale3_mode && (tgt == TGT_EPROM);
  end

  // highest needed phase starts the access
  always_comb begin
    first = '0;
    for (int i = 0; i < NUM_PH; i++) begin
      if (need[i]) first = IDX_W'(i);
    end
  end

  // highest needed phase strictly below the current one
  always_comb begin
    nxt    = '0;
    nxt_ok = 1'b0;
    for (int i = 0; i < NUM_PH; i++) begin
      if (need[i] && (i < int'(cur))) begin
        nxt    = IDX_W'(i);
        nxt_ok = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pbm_seq.sv
module pbm_seq
  import pbm_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [WAIT_W-1:0] wait_cnt,
  input  logic [IDX_W-1:0]  first,
  input  logic [IDX_W-1:0]  nxt,
  input  logic              nxt_ok,
  output st_e               state,
  output logic [IDX_W-1:0]  ph,
  output logic              sub,
  output logic              last,
  output logic              done
);

  logic [WAIT_W-1:0] cnt;

  assign last = (state == ST_DATA) && (cnt == wait_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ph    <= '0;
      sub   <= 1'b0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_TURN);
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_ADDR;
            ph    <= first;
            sub   <= 1'b0;
          end
        end
        ST_ADDR: begin
          if (!sub) begin
            sub <= 1'b1;
          end else begin
            sub <= 1'b0;
            if (nxt_ok) begin
              ph <= nxt;
            end else begin
              state <= wr ? ST_DATA : ST_PARK_R;
              cnt   <= '0;
            end
          end
        end
        ST_PARK_R: state <= ST_GAP;
        ST_GAP: begin
          state <= ST_DATA;
          cnt   <= '0;
        end
        ST_DATA: begin
          if (cnt == wait_cnt) state <= wr ? ST_PARK_W : ST_TURN;
          else                 cnt   <= cnt + 1'b1;
        end
        ST_PARK_W: state <= ST_TURN;
        ST_TURN:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pbm_pin_drv.sv
module pbm_pin_drv
  import pbm_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int ADDR_W = NUM_PH * BUS_W
) (
  input  st_e                state,
  input  logic [IDX_W-1:0]   ph,
  input  logic               sub,
  input  tgt_e               tgt,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [2*BUS_W-1:0] wdata,
  input  logic               wide,
  input  logic               par_en,
  input  logic               ale3_mode,
  output logic               sel_eprom_n,
  output logic               sel_phy1_n,
  output logic               sel_phy2_n,
  output logic               ale1,
  output logic               ale2,
  output logic               a16_o,
  output logic               a17_o,
  output logic [BUS_W-1:0]   bus_d_o,
  output logic               bus_d_oe,
  output logic [BUS_W-1:0]   bus_hi_o,
  output logic               bus_hi_oe,
  output logic               par_o,
  output logic               par_oe
);

  logic active, is_ep, in_addr, in_data, drive, wide_phy;
  logic [BUS_W-1:0]  d;
  logic [NUM_PH-1:0] strobe;

  always_comb begin
    active   = (state != ST_IDLE);
    is_ep    = (tgt == TGT_EPROM);
    wide_phy = wide && !is_ep;
    in_addr  = (state == ST_ADDR);
    in_data  = (state == ST_DATA);
    drive    = in_addr || (state == ST_PARK_R) || (state == ST_PARK_W) ||
               (in_data && wr);
    d = '1;
    if (in_addr)            d = addr[int'(ph)*BUS_W +: BUS_W];
    else if (in_data && wr) d = wdata[BUS_W-1:0];
    for (int i = 0; i < NUM_PH; i++) begin
      strobe[i] = in_addr && !sub && (int'(ph) == i);
    end
  end

  assign bus_d_o     = d;
  assign bus_d_oe    = drive;
  assign par_o       = ~^d;
  assign par_oe      = par_en && drive;
  assign ale1        = strobe[0];
  assign ale2        = strobe[1];
  assign a16_o       = ale3_mode ? strobe[2] : (active && is_ep && addr[2*BUS_W]);
  assign a17_o       = active && is_ep && addr[2*BUS_W+1];
  assign sel_eprom_n = !(in_data && tgt == TGT_EPROM);
  assign sel_phy1_n  = !(in_data && tgt == TGT_PHY1);
  assign sel_phy2_n  = !(in_data && tgt == TGT_PHY2);
  assign bus_hi_oe   = wide_phy && wr && (in_data || state == ST_PARK_W);
  assign bus_hi_o    = in_data ? wdata[2*BUS_W-1:BUS_W] : '1;

endmodule

// File: rtl/pbm_rd_cap.sv
module pbm_rd_cap #(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               cap,
  input  logic               wide,
  input  logic               par_en,
  input  logic [BUS_W-1:0]   d_lo,
  input  logic [BUS_W-1:0]   d_hi,
  input  logic               par_i,
  output logic [2*BUS_W-1:0] rdata,
  output logic               perr
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rdata <= '0;
      perr  <= 1'b0;
    end else if (cap) begin
      rdata <= {(wide ? d_hi : {BUS_W{1'b0}}), d_lo};
      perr  <= par_en && (par_i != ~^d_lo);
    end
  end

endmodule

// File: rtl/pbm_bus_master.sv
module pbm_bus_master
  import pbm_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int WAIT_W = 4,
  localparam int ADDR_W = NUM_PH * BUS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_target,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [2*BUS_W-1:0] req_wdata,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic               cfg_wide,
  input  logic               cfg_parity,
  output logic               busy,
  output logic               rsp_done,
  output logic [2*BUS_W-1:0] rsp_rdata,
  output logic               rsp_perr,
  output logic               sel_eprom_n,
  output logic               sel_phy1_n,
  output logic               sel_phy2_n,
  output logic               ale1,
  output logic               ale2,
  input  logic               a16_strap_i,
  output logic               a16_o,
  output logic               a17_o,
  output logic [BUS_W-1:0]   bus_d_o,
  input  logic [BUS_W-1:0]   bus_d_i,
  output logic               bus_d_oe,
  output logic [BUS_W-1:0]   bus_hi_o,
  input  logic [BUS_W-1:0]   bus_hi_i,
  output logic               bus_hi_oe,
  output logic               par_o,
  input  logic               par_i,
  output logic               par_oe
);

  st_e               state;
  tgt_e              tgt_q;
  logic              wr_q, wide_q, paren_q, ale3_mode_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [2*BUS_W-1:0] wdata_q;
  logic [WAIT_W-1:0]  wait_q;
  logic              accept, sub, last;
  logic [IDX_W-1:0]  ph, first, nxt;
  logic              nxt_ok;
  logic [NUM_PH-1:0] need;

  assign accept = req_valid && (state == ST_IDLE) &&
                  (req_target != 2'(TGT_NONE));
  assign busy   = (state != ST_IDLE);

  // strap is read on every reset cycle; pulled low selects third strobe
  always_ff @(posedge clk) begin
    if (rst) ale3_mode_q <= !a16_strap_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q   <= TGT_EPROM;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wait_q  <= '0;
      wide_q  <= 1'b0;
      paren_q <= 1'b0;
    end else if (accept) begin
      tgt_q   <= tgt_e'(req_target);
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wait_q  <= cfg_wait;
      wide_q  <= cfg_wide;
      paren_q <= cfg_parity;
    end
  end

  // plan for the request being taken while idle, for the latched one after
  tgt_e tgt_plan;
  logic wide_plan;
  assign tgt_plan  = busy ? tgt_q  : tgt_e'(req_target);
  assign wide_plan = busy ? wide_q : cfg_wide;

  pbm_phase_plan u_plan (
    .tgt       (tgt_plan),
    .ale3_mode (ale3_mode_q),
    .wide      (wide_plan),
    .cur       (ph),
    .need      (need),
    .first     (first),
    .nxt       (nxt),
    .nxt_ok    (nxt_ok)
  );

  pbm_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .wr       (wr_q),
    .wait_cnt (wait_q),
    .first    (first),
    .nxt      (nxt),
    .nxt_ok   (nxt_ok),
    .state    (state),
    .ph       (ph),
    .sub      (sub),
    .last     (last),
    .done     (rsp_done)
  );

  pbm_pin_drv #(.BUS_W(BUS_W)) u_pins (
    .state       (state),
    .ph          (ph),
    .sub         (sub),
    .tgt         (tgt_q),
    .wr          (wr_q),
    .addr        (addr_q),
    .wdata       (wdata_q),
    .wide        (wide_q),
    .par_en      (paren_q),
    .ale3_mode   (ale3_mode_q),
    .sel_eprom_n (sel_eprom_n),
    .sel_phy1_n  (sel_phy1_n),
    .sel_phy2_n  (sel_phy2_n),
    .ale1        (ale1),
    .ale2        (ale2),
    .a16_o       (a16_o),
    .a17_o       (a17_o),
    .bus_d_o     (bus_d_o),
    .bus_d_oe    (bus_d_oe),
    .bus_hi_o    (bus_hi_o),
    .bus_hi_oe   (bus_hi_oe),
    .par_o       (par_o),
    .par_oe      (par_oe)
  );

  pbm_rd_cap #(.BUS_W(BUS_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .cap    (last && !wr_q),
    .wide   (wide_q && (tgt_q != TGT_EPROM)),
    .par_en (paren_q),
    .d_lo   (bus_d_i),
    .d_hi   (bus_hi_i),
    .par_i  (par_i),
    .rdata  (rsp_rdata),
    .perr   (rsp_perr)
  );

  logic unused_need;
  assign unused_need = ^need;

endmodule

// File: rtl/pbm_bus_chk.sv
module pbm_bus_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             rsp_done,
  input logic             sel_eprom_n,
  input logic             sel_phy1_n,
  input logic             sel_phy2_n,
  input logic             ale1,
  input logic             ale2,
  input logic [BUS_W-1:0] bus_d_o,
  input logic             bus_d_oe,
  input logic             par_oe
);

  logic sel_act;
  assign sel_act = !(sel_eprom_n && sel_phy1_n && sel_phy2_n);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (sel_eprom_n && sel_phy1_n && sel_phy2_n && !ale1 && !ale2 &&
             !bus_d_oe && !busy && !rsp_done));

  a_r2_single_select: assert property (@(posedge clk) disable iff (rst)
    $countones({~sel_eprom_n, ~sel_phy1_n, ~sel_phy2_n}) <= 1);

  a_r2_no_strobe_under_select: assert property (@(posedge clk) disable iff (rst)
    sel_act |-> (!ale1 && !ale2));

  a_r3_ale1_one_clock: assert property (@(posedge clk) disable iff (rst)
    ale1 |=> !ale1);

  a_r9_parity_with_bus: assert property (@(posedge clk) disable iff (rst)
    par_oe |-> bus_d_oe);

  a_r10_park_high: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_d_oe) |-> ($past(bus_d_o) == {BUS_W{1'b1}}));

  a_r10_gap_after_read: assert property (@(posedge clk) disable iff (rst)
    ($fell(sel_act) && !$past(bus_d_oe)) |-> !bus_d_oe);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  a_r11_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !busy);

endmodule

bind pbm_bus_master pbm_bus_chk #(.BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .rsp_done    (rsp_done),
  .sel_eprom_n (sel_eprom_n),
  .sel_phy1_n  (sel_phy1_n),
  .sel_phy2_n  (sel_phy2_n),
  .ale1        (ale1),
  .ale2        (ale2),
  .bus_d_o     (bus_d_o),
  .bus_d_oe    (bus_d_oe),
  .par_oe      (par_oe)
);

// File: tb/pbm_bus_master_bench.sv
module pbm_bus_master_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_target = 2'd0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  cfg_wait = 4'd0;
  logic        cfg_wide = 1'b0;
  logic        cfg_parity = 1'b0;
  logic        busy, rsp_done, rsp_perr;
  logic [15:0] rsp_rdata;
  logic        sel_eprom_n, sel_phy1_n, sel_phy2_n, ale1, ale2;
  logic        a16_strap_i = 1'b1;
  logic        a16_o, a17_o;
  logic [7:0]  bus_d_o, bus_d_i, bus_hi_o, bus_hi_i;
  logic        bus_d_oe, bus_hi_oe, par_o, par_i, par_oe;

  always #5 clk = ~clk;

  pbm_bus_master u_pbm_bus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_wait(cfg_wait), .cfg_wide(cfg_wide), .cfg_parity(cfg_parity),
    .busy(busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
    .sel_eprom_n(sel_eprom_n), .sel_phy1_n(sel_phy1_n), .sel_phy2_n(sel_phy2_n),
    .ale1(ale1), .ale2(ale2), .a16_strap_i(a16_strap_i), .a16_o(a16_o),
    .a17_o(a17_o), .bus_d_o(bus_d_o), .bus_d_i(bus_d_i), .bus_d_oe(bus_d_oe),
    .bus_hi_o(bus_hi_o), .bus_hi_i(bus_hi_i), .bus_hi_oe(bus_hi_oe),
    .par_o(par_o), .par_i(par_i), .par_oe(par_oe)
  );

  int total = 0, bad = 0, cyc = 0, start_cyc = 0, done_cnt = 0;
  bit finished = 0;
  bit strap_lo = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // target model: correct data only on the last select clock
  logic [15:0] rd_val = '0;
  logic        bad_par = 1'b0;
  logic [4:0]  sel_cnt = '0;
  logic        sel_act, last_sel;
  assign sel_act  = !(sel_eprom_n && sel_phy1_n && sel_phy2_n);
  assign last_sel = sel_act && (sel_cnt == {1'b0, cfg_wait});
  assign bus_d_i  = (sel_act && !bus_d_oe) ? (last_sel ? rd_val[7:0] : ~rd_val[7:0]) : 8'h00;
  assign bus_hi_i = last_sel ? rd_val[15:8] : ~rd_val[15:8];
  assign par_i    = (~^bus_d_i) ^ bad_par;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    sel_cnt <= sel_act ? sel_cnt + 5'd1 : 5'd0;
  end

  typedef struct {
    logic [1:0]  tg;
    logic        wr;
    logic [23:0] ad;
    logic [15:0] wd;
    logic [15:0] rexp;
    logic        pexp;
    logic [3:0]  wt;
    logic        wide_phy;
    logic        pen;
    logic        slo;
  } item_t;
  item_t q[$];

  // monitor state
  int n1 = 0, n2 = 0, n3 = 0, selc = 0;
  logic [7:0] lat1, lat2, lat3, wlo, whi, prev_d;
  logic [1:0] seen_tg;
  logic a16s, a17s, pseen, pon, prev_oe = 1'b0;

  task automatic clear_mon();
    n1 = 0; n2 = 0; n3 = 0; selc = 0;
    lat1 = 0; lat2 = 0; lat3 = 0; wlo = 0; whi = 0;
    seen_tg = 2'd3; a16s = 0; a17s = 0; pseen = 0; pon = 0;
  endtask

  task automatic score();
    item_t it;
    int nph, lat_exp;
    if (q.size() == 0) begin
      chk("R11 unexpected done", 1, 0);
      return;
    end
    it = q.pop_front();
    nph = 1 + (it.wide_phy ? 0 : 1) + ((it.slo && it.tg == 2'd0) ? 1 : 0);
    lat_exp = 2 * nph + int'(it.wt) + 1 + (it.wr ? 2 : 3);
    chk("R11 done latency", cyc - start_cyc, lat_exp);
    chk("R3 ale1 count", n1, 1);
    chk("R3 low byte", lat1, it.ad[7:0]);
    chk("R4 ale2 count", n2, it.wide_phy ? 0 : 1);
    if (!it.wide_phy) chk("R4 middle byte", lat2, it.ad[15:8]);
    chk("R5 third strobe count", n3, (it.slo && it.tg == 2'd0) ? 1 : 0);
    if (it.slo && it.tg == 2'd0) chk("R5 high byte", lat3, it.ad[23:16]);
    chk("R2 target select", seen_tg, it.tg);
    chk("R7 select clocks", selc, int'(it.wt) + 1);
    if (it.tg == 2'd0) begin
      chk("R6 a17 eprom", a17s, it.ad[17]);
      chk("R6 a16 eprom", a16s, it.slo ? 1'b0 : it.ad[16]);
    end else begin
      chk("R6 a17 phy", a17s, 0);
      chk("R6 a16 phy", a16s, 0);
    end
    if (it.wr) begin
      chk("R7 write data", wlo, it.wd[7:0]);
      if (it.wide_phy) chk("R8 upper write", whi, it.wd[15:8]);
      chk("R9 parity driven", pon, it.pen);
      if (it.pen) chk("R9 parity value", pseen, ~^it.wd[7:0]);
    end
    chk("R7 R8 read data", rsp_rdata, it.rexp);
    chk("R9 parity error", rsp_perr, it.pexp);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ale1) begin n1++; lat1 = bus_d_o; end
      if (ale2) begin n2++; lat2 = bus_d_o; end
      if (strap_lo && a16_o) begin n3++; lat3 = bus_d_o; end
      if (sel_act) begin
        selc++;
        seen_tg = !sel_eprom_n ? 2'd0 : (!sel_phy1_n ? 2'd1 : 2'd2);
        a16s = a16_o; a17s = a17_o;
        if (bus_d_oe) wlo = bus_d_o;
        if (bus_hi_oe) whi = bus_hi_o;
        if (par_oe) begin pon = 1; pseen = par_o; end
      end
      if (prev_oe && !bus_d_oe) chk("R10 park high before release", prev_d, 8'hFF);
      prev_oe = bus_d_oe; prev_d = bus_d_o;
      if (rsp_done) begin
        done_cnt++;
        score();
        clear_mon();
      end
    end else begin
      prev_oe = 1'b0;
    end
  end

  task automatic do_reset(input logic strap);
    a16_strap_i = strap;
    strap_lo = !strap;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_mon();
  endtask

  task automatic access(input logic [1:0] tg, input logic wr, input logic [23:0] ad,
                        input logic [15:0] wd, input logic [15:0] rv, input logic bp,
                        input bit poke);
    item_t it;
    it.tg = tg; it.wr = wr; it.ad = ad; it.wd = wd; it.wt = cfg_wait;
    it.wide_phy = cfg_wide && (tg != 2'd0);
    it.pen = cfg_parity; it.slo = strap_lo;
    it.rexp = wr ? 16'h0 : {(it.wide_phy ? rv[15:8] : 8'h00), rv[7:0]};
    it.pexp = !wr && cfg_parity && bp;
    rd_val = rv; bad_par = bp;
    q.push_back(it);
    @(negedge clk);
    req_target = tg; req_write = wr; req_addr = ad; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    start_cyc = cyc;
    chk("R11 busy after accept", busy, 1);
    if (poke) begin
      @(negedge clk);
      req_target = 2'd1; req_write = 1'b1; req_addr = 24'h0000AA; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R11 watchdog expired act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int dc;
    clear_mon();
    do_reset(1'b1);
    // R1 reset state
    chk("R1 selects high", {sel_eprom_n, sel_phy1_n, sel_phy2_n}, 3'b111);
    chk("R1 strobes low", {ale1, ale2, a16_o, a17_o}, 4'b0000);
    chk("R1 drivers off", {bus_d_oe, bus_hi_oe, par_oe}, 3'b000);
    chk("R1 idle", {busy, rsp_done}, 2'b00);

    // narrow, no parity, strap high
    cfg_wait = 4'd2;
    access(2'd0, 1'b1, 24'h3A5C71, 16'h00B4, 16'h0, 1'b0, 0);
    cfg_wait = 4'd0;
    access(2'd0, 1'b0, 24'h02F00D, 16'h0, 16'h00C6, 1'b0, 0);
    cfg_wait = 4'd3;
    access(2'd1, 1'b1, 24'h0012E5, 16'h005A, 16'h0, 1'b0, 0);
    access(2'd2, 1'b0, 24'h0034A0, 16'h0, 16'h0039, 1'b0, 0);

    // parity on
    cfg_parity = 1'b1; cfg_wait = 4'd1;
    access(2'd1, 1'b0, 24'h000140, 16'h0, 16'h0017, 1'b0, 0);
    access(2'd2, 1'b0, 24'h000141, 16'h0, 16'h0081, 1'b1, 0);
    access(2'd0, 1'b1, 24'h01FFFE, 16'h0037, 16'h0, 1'b0, 0);

    // wide PHY mode
    cfg_parity = 1'b0; cfg_wide = 1'b1; cfg_wait = 4'd4;
    access(2'd2, 1'b1, 24'h00BE77, 16'hD00F, 16'h0, 1'b0, 0);
    access(2'd1, 1'b0, 24'h00CD12, 16'h0, 16'hA55A, 1'b0, 0);
    access(2'd0, 1'b0, 24'h000E21, 16'h0, 16'h9966, 1'b0, 0);
    cfg_wide = 1'b0;

    // ignored requests
    cfg_wait = 4'd2;
    dc = done_cnt;
    access(2'd0, 1'b0, 24'h00A0A0, 16'h0, 16'h0042, 1'b0, 1);
    repeat (30) @(negedge clk);
    chk("R11 request while busy ignored", done_cnt, dc + 1);
    @(negedge clk);
    req_target = 2'd3; req_write = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 target code 3 not accepted", busy, 0);
    repeat (20) @(negedge clk);
    chk("R11 no done for code 3", done_cnt, dc + 1);

    // strap low: third strobe
    do_reset(1'b0);
    chk("R1 strobes low strap mode", {ale1, ale2, a16_o, a17_o}, 4'b0000);
    cfg_wait = 4'd1;
    access(2'd0, 1'b0, 24'hC3697E, 16'h0, 16'h00E1, 1'b0, 0);
    access(2'd0, 1'b1, 24'h5B0204, 16'h0071, 16'h0, 1'b0, 0);
    access(2'd1, 1'b1, 24'hFF1357, 16'h0024, 16'h0, 1'b0, 0);
    cfg_wide = 1'b1;
    access(2'd2, 1'b0, 24'h77AB09, 16'h0, 16'h3C5D, 1'b0, 0);
    cfg_wide = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule